// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Pin Interrupts

This block drives and samples sixteen general-purpose pins from a small 32-bit register bus. Software writes to it by byte offset, one word at a time. Each pin can be an input or an output. An output pin uses either push-pull or open-drain drive. The output-value and direction registers can each be written whole, or through alias words. One alias sets only the bits written as one, and the other clears only those bits.

Each pin also watches its synchronized input for one of five trigger conditions: a rising edge, a falling edge, either edge, a low level or a high level. A hit latches a sticky bit in a status word. A single interrupt line is high whenever any status bit is set. To acknowledge, software reads the status word and writes the same value to the status-clear alias. A status-set alias lets software raise bits itself.

Register map (byte offsets): 0x00 output value, 0x04 output set, 0x08 output clear, 0x0C direction, 0x10 direction set, 0x14 direction clear, 0x18 input value (read only), 0x1C status, 0x20 status set, 0x24 status clear, 0x28 + 4*n control word of pin n.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the output, direction, status and all control registers read zero, `pad_oe` is all zero and `irq` is low.
- R2: A write to 0x00 replaces the output latch. A write to 0x04 ORs the one-bits of the data into it. A write to 0x08 clears the bits that are one. Zero bits leave the latch unchanged, and 0x00 reads the latch back.
- R3: The direction register (0x0C, set alias 0x10, clear alias 0x14, same alias rules as R2) makes pin n an output when bit n is one. For a push-pull pin, `pad_oe[n]` equals direction bit n and `pad_out[n]` equals output bit n.
- R4: Control bit 2 set to one selects open drain. Such a pin has `pad_out[n]` at 0 and `pad_oe[n]` high only when its direction bit is one and its output bit is zero.
- R5: Reading 0x18 returns the pin levels through a two-flop synchronizer. A pin change made before clock edge k is visible in the read after edge k+1 and not after edge k.
- R6: A trigger field (control bits 9:7) of 001 detects rising edges, 010 falling edges and 011 either edge of the synchronized pin. A detected edge sets status bit n, which stays set until it is cleared.
- R7: A trigger field of 100 (low level) or 101 (high level) sets status bit n on every cycle the level holds. A clear has no lasting effect until the pin leaves the active level.
- R8: A trigger field of 000 (and the unused codes 110 and 111) never sets the status bit, whatever the pin does.
- R9: Writing to 0x24 clears the status bits written as one, and writing to 0x20 sets them. When a pin event and a clear of the same bit fall in the same cycle, the bit stays set.
- R10: `irq` is high exactly when some status bit is set. Status bits 31:16 always read zero.
- R11: A control word reads back bits 0, 2 and 9:7 as written and all other bits as zero. Bit 0 (output source) is stored but changes no pad behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 16 | Pin levels from the pads (asynchronous) |
| pad_out | output | 16 | Value driven onto each pad |
| pad_oe | output | 16 | Pad output enable per pin |
| irq | output | 1 | Combined pin interrupt |

## Verification
The hardest case to reach from the ports is a pin event that lands in the same cycle as a status-clear write for that bit. The synchronizer delay makes an edge land on an exact cycle only with careful timing. The bench reaches this case through the level modes, where the event repeats on every cycle the level holds, so any clear written while the pin sits at its active level collides with an event. Every pin is swept through every trigger code across a full low-high-low excursion. After each step the whole status word and `irq` are compared, which also shows that no other pin was disturbed.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    // byte offsets of the fixed registers
    localparam logic [7:0] OFS_OUT      = 8'h00;
    localparam logic [7:0] OFS_OUT_SET  = 8'h04;
    localparam logic [7:0] OFS_OUT_CLR  = 8'h08;
    localparam logic [7:0] OFS_DIR      = 8'h0C;
    localparam logic [7:0] OFS_DIR_SET  = 8'h10;
    localparam logic [7:0] OFS_DIR_CLR  = 8'h14;
    localparam logic [7:0] OFS_PINS     = 8'h18;
    localparam logic [7:0] OFS_STAT     = 8'h1C;
    localparam logic [7:0] OFS_STAT_SET = 8'h20;
    localparam logic [7:0] OFS_STAT_CLR = 8'h24;
    localparam logic [7:0] OFS_CFG_BASE = 8'h28;

    // trigger field codes (control bits 9:7)
    typedef enum logic [2:0] {
        TRG_OFF  = 3'b000,
        TRG_RISE = 3'b001,
        TRG_FALL = 3'b010,
        TRG_ANY  = 3'b011,
        TRG_LOW  = 3'b100,
        TRG_HIGH = 3'b101
    } trig_e;

    typedef struct packed {
        logic [2:0] trig;
        logic       drv_od;
        logic       src_alt;
    } pin_cfg_t;

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.meta   = async_in;
        sy_d.stable = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign sync_out = sy_q.stable;
endmodule

// File: rtl/gpio_trig.sv
`timescale 1ns/1ps
module gpio_trig
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPIN-1:0]      smp,
    input  logic [NPIN-1:0][2:0] trig_sel,
    output logic [NPIN-1:0]      evt
);
    logic [NPIN-1:0] prev_d, prev_q;

    always_comb prev_d = smp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic rise, fall, hit;
        assign rise = smp[i] & ~prev_q[i];
        assign fall = ~smp[i] & prev_q[i];
        always_comb begin
            case (trig_sel[i])
                TRG_RISE: hit = rise;
                TRG_FALL: hit = fall;
                TRG_ANY:  hit = rise | fall;
                TRG_LOW:  hit = ~smp[i];
                TRG_HIGH: hit = smp[i];
                default:  hit = 1'b0;
            endcase
        end
        assign evt[i] = hit;
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPIN   = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic              irq
);
    localparam int IDX_W = (NPIN > 1) ? $clog2(NPIN) : 1;
    localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(OFS_CFG_BASE);
    localparam logic [ADDR_W-1:0] CFG_SPAN = ADDR_W'(4 * NPIN);

    typedef struct packed {
        logic [NPIN-1:0]           out;
        logic [NPIN-1:0]           dir;
        logic [NPIN-1:0]           status;
        pin_cfg_t [NPIN-1:0]       cfg;
    } regs_t;

    regs_t st_d, st_q;

    logic [NPIN-1:0]      pin_s;
    logic [NPIN-1:0][2:0] trig_sel;
    logic [NPIN-1:0]      hw_evt;
    logic [NPIN-1:0]      out_q, status_q, od_mask, trig_off;
    logic [NPIN-1:0]      wd;
    logic [ADDR_W-1:0]    cfg_off;
    logic                 cfg_hit;
    logic [IDX_W-1:0]     cfg_idx;

    gpio_sync #(.W(NPIN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_s)
    );

    gpio_trig #(.NPIN(NPIN)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp      (pin_s),
        .trig_sel (trig_sel),
        .evt      (hw_evt)
    );

    assign wd      = bus_wdata[NPIN-1:0];
    assign cfg_off = bus_addr - CFG_BASE;
    assign cfg_hit = (bus_addr >= CFG_BASE) && (cfg_off < CFG_SPAN) && (bus_addr[1:0] == 2'b00);
    assign cfg_idx = cfg_off[IDX_W+1:2];

    // next-state computation: bus write first, then pin events (events win)
    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFS_OUT):      st_d.out    = wd;
                ADDR_W'(OFS_OUT_SET):  st_d.out    = st_q.out | wd;
                ADDR_W'(OFS_OUT_CLR):  st_d.out    = st_q.out & ~wd;
                ADDR_W'(OFS_DIR):      st_d.dir    = wd;
                ADDR_W'(OFS_DIR_SET):  st_d.dir    = st_q.dir | wd;
                ADDR_W'(OFS_DIR_CLR):  st_d.dir    = st_q.dir & ~wd;
                ADDR_W'(OFS_STAT_SET): st_d.status = st_q.status | wd;
                ADDR_W'(OFS_STAT_CLR): st_d.status = st_q.status & ~wd;
                default: begin
                    if (cfg_hit) begin
                        st_d.cfg[cfg_idx].trig    = bus_wdata[9:7];
                        st_d.cfg[cfg_idx].drv_od  = bus_wdata[2];
                        st_d.cfg[cfg_idx].src_alt = bus_wdata[0];
                    end
                end
            endcase
        end
        st_d.status = st_d.status | hw_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_OUT), ADDR_W'(OFS_OUT_SET), ADDR_W'(OFS_OUT_CLR):
                bus_rdata[NPIN-1:0] = st_q.out;
            ADDR_W'(OFS_DIR), ADDR_W'(OFS_DIR_SET), ADDR_W'(OFS_DIR_CLR):
                bus_rdata[NPIN-1:0] = st_q.dir;
            ADDR_W'(OFS_PINS):
                bus_rdata[NPIN-1:0] = pin_s;
            ADDR_W'(OFS_STAT), ADDR_W'(OFS_STAT_SET), ADDR_W'(OFS_STAT_CLR):
                bus_rdata[NPIN-1:0] = st_q.status;
            default: begin
                if (cfg_hit) begin
                    bus_rdata[9:7] = st_q.cfg[cfg_idx].trig;
                    bus_rdata[2]   = st_q.cfg[cfg_idx].drv_od;
                    bus_rdata[0]   = st_q.cfg[cfg_idx].src_alt;
                end
            end
        endcase
    end

    // pad drive and per-pin views
    for (genvar i = 0; i < NPIN; i++) begin : g_pad
        assign trig_sel[i] = st_q.cfg[i].trig;
        assign od_mask[i]  = st_q.cfg[i].drv_od;
        assign trig_off[i] = (st_q.cfg[i].trig == TRG_OFF);
        assign pad_oe[i]   = st_q.dir[i] & ~(st_q.cfg[i].drv_od & st_q.out[i]);
        assign pad_out[i]  = st_q.out[i] & ~st_q.cfg[i].drv_od;
    end

    assign out_q    = st_q.out;
    assign status_q = st_q.status;
    assign irq      = |st_q.status;
endmodule

// File: rtl/gpio_irq_chk.sv
`timescale 1ns/1ps
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPIN   = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NPIN-1:0]   pad_out,
    input logic [NPIN-1:0]   pad_oe,
    input logic [NPIN-1:0]   out_q,
    input logic [NPIN-1:0]   status_q,
    input logic [NPIN-1:0]   hw_evt,
    input logic [NPIN-1:0]   od_mask,
    input logic [NPIN-1:0]   trig_off
);
    p_out_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_OUT_SET)) |=>
        ((out_q & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

    p_out_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_OUT_CLR)) |=>
        ((out_q & $past(bus_wdata[NPIN-1:0])) == '0));

    p_od_never_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_out & od_mask) == '0));

    p_off_no_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_evt & trig_off) == '0));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_STAT_CLR)) |=>
        ((status_q & $past(bus_wdata[NPIN-1:0]) & ~$past(hw_evt)) == '0));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_STAT_CLR) && hw_evt != '0) |=>
        ((status_q & $past(hw_evt)) == $past(hw_evt)));

    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_STAT)) |-> (bus_rdata[31:NPIN] == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .out_q     (out_q),
    .status_q  (status_q),
    .hw_evt    (hw_evt),
    .od_mask   (od_mask),
    .trig_off  (trig_off)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pad_out, pad_oe;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_stat(input string req, input string what, input logic [15:0] exp);
        logic [31:0] v;
        rd(8'h1C, v);
        chk(req, what, v, {16'h0, exp});
        chk("R10", {what, " irq"}, {31'h0, irq}, {31'h0, (exp != 16'h0)});
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        if (!done) begin
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] ob, db, om;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(8'h00, v); chk("R1", "out reset", v, 32'h0);
        rd(8'h0C, v); chk("R1", "dir reset", v, 32'h0);
        rd(8'h1C, v); chk("R1", "status reset", v, 32'h0);
        rd(8'h28, v); chk("R1", "cfg0 reset", v, 32'h0);
        rd(8'h64, v); chk("R1", "cfg15 reset", v, 32'h0);
        chk("R1", "pad_oe reset", {16'h0, pad_oe}, 32'h0);
        chk("R1", "irq reset", {31'h0, irq}, 32'h0);

        // R2 output latch and aliases
        wr(8'h00, 32'hFFFF_A5A5); rd(8'h00, v); chk("R2", "out write", v, 32'h0000_A5A5);
        wr(8'h04, 32'h0000_0F00); rd(8'h00, v); chk("R2", "out set", v, 32'h0000_AFA5);
        wr(8'h08, 32'h0000_00A1); rd(8'h00, v); chk("R2", "out clear", v, 32'h0000_AF04);
        wr(8'h04, 32'h0000_0000); rd(8'h00, v); chk("R2", "out set zero", v, 32'h0000_AF04);
        ob = 16'hAF04;

        // R3 direction and push-pull pads
        wr(8'h0C, 32'h0); wr(8'h10, 32'h0000_00FF); wr(8'h14, 32'h0000_000F);
        rd(8'h0C, v); chk("R3", "dir alias", v, 32'h0000_00F0);
        db = 16'h00F0;
        chk("R3", "pp pad_oe", {16'h0, pad_oe}, {16'h0, db});
        chk("R3", "pp pad_out", {16'h0, pad_out}, {16'h0, ob});

        // R4 open drain on pins 4 and 6, R11 source bit on pin 5
        wr(8'h28 + 8'd16, 32'h4);
        wr(8'h28 + 8'd24, 32'h4);
        wr(8'h28 + 8'd20, 32'h1);
        om = 16'h0050;
        for (int k = 0; k < 4; k++) begin
            ob = (k[0]) ? (ob | 16'h0070) : (ob & ~16'h0070);
            wr(8'h00, {16'h0, ob});
            if (k == 2) begin db = 16'h00A0; wr(8'h0C, {16'h0, db}); end
            chk("R4", "od pad_oe", {16'h0, pad_oe}, {16'h0, db & ~(om & ob)});
            chk("R4", "od pad_out", {16'h0, pad_out}, {16'h0, ob & ~om});
            chk("R11", "src bit no effect", {31'h0, pad_out[5]}, {31'h0, ob[5]});
        end

        // R11 control readback
        wr(8'h34, 32'hFFFF_FFFF); rd(8'h34, v); chk("R11", "cfg readback", v, 32'h0000_0385);
        wr(8'h34, 32'h0); rd(8'h34, v); chk("R11", "cfg zero", v, 32'h0);
        wr(8'h28 + 8'd16, 32'h0); wr(8'h28 + 8'd24, 32'h0); wr(8'h28 + 8'd20, 32'h0);

        // R5 input synchronizer latency, walking ones
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            pin_in = 16'(1 << i);
            idle(1); rd(8'h18, v);
            chk("R5", "input after one edge", v, (i == 0) ? 32'h0 : 32'(1 << (i - 1)));
            idle(1); rd(8'h18, v);
            chk("R5", "input after two edges", v, 32'(1 << i));
        end
        @(negedge clk); pin_in = '0; idle(3);

        // R9/R10 status aliases
        wr(8'h20, 32'hFFFF_FFFF); chk_stat("R10", "set all", 16'hFFFF);
        wr(8'h24, 32'h0000_00FF); chk_stat("R9", "clear low byte", 16'hFF00);
        wr(8'h24, 32'h0000_FF00); chk_stat("R9", "clear rest", 16'h0000);

        // R6 R7 R8 sweep: every pin through every trigger code
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 7; m++) begin
                logic [2:0] code;
                logic [15:0] b;
                bit lo, hi, er, ef;
                string rq;
                code = (m == 6) ? 3'b110 : 3'(m);
                b  = 16'(1 << p);
                lo = (code == 3'b100);
                hi = (code == 3'b101);
                er = (code == 3'b001) || (code == 3'b011);
                ef = (code == 3'b010) || (code == 3'b011);
                rq = (lo || hi) ? "R7" : ((er || ef) ? "R6" : "R8");
                wr(8'h28 + 8'(4 * p), 32'h0);
                pin_in = '0; idle(3);
                wr(8'h24, 32'hFFFF);
                wr(8'h28 + 8'(4 * p), {22'h0, code, 7'h0});
                idle(3);
                chk_stat(rq, "idle low", lo ? b : 16'h0);
                wr(8'h24, 32'hFFFF); idle(2);
                chk_stat(lo ? "R9" : rq, "clear while low", lo ? b : 16'h0);
                pin_in[p] = 1'b1; idle(4);
                chk_stat(rq, "after rise", (er || hi || lo) ? b : 16'h0);
                wr(8'h24, 32'hFFFF); idle(2);
                chk_stat(hi ? "R9" : rq, "clear while high", hi ? b : 16'h0);
                pin_in[p] = 1'b0; idle(4);
                chk_stat(rq, "after fall", (ef || lo || hi) ? b : 16'h0);
                wr(8'h24, 32'hFFFF); idle(2);
                chk_stat(rq, "final clear", lo ? b : 16'h0);
                wr(8'h28 + 8'(4 * p), 32'h0);
                wr(8'h24, 32'hFFFF);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule